// File: doc/BRIEF.md
# Compression status invalidation controller

This block holds the per-chunk status table used by a display frame-buffer compressor. Each entry is a 5-bit code. The value 5'b11111 is reserved and means that the chunk holds no valid compressed data. When the compressor fetches an entry that holds this code, it reads the chunk from the uncompressed buffer. On its next pass it tries to compress that chunk again. After a successful compression the compressor writes the new code back. When a chunk could not be stored, it writes the reserved code back instead.

A 32-bit event mask register selects which single-cycle event pulses invalidate the whole table. An enabled event starts a sweep that writes the reserved code into one entry per clock cycle, from entry 0 upward. A busy flag stays high while the sweep runs. A new enabled event during a sweep restarts it at entry 0. While a sweep is running, compressor writes to entries that the sweep has not yet cleared are dropped, so no stale result can survive a newer invalidation.

The event bit positions are fixed:
- 0: display register update
- 2: compression enable changed
- 3: source select changed
- 4: minimum compression changed
- 5: alpha compression enable changed
- 6: zero-alpha skip enable changed
- 7: force-copy changed
- 28: memory write by any client other than the capture client
- 29: static-screen signal went inactive

All other bits are inert. This includes the region-hit events on bits 16 to 19, because region-hit invalidation is disabled.

Top module: `cmi_ctrl`

## Requirements
- R1: After a synchronous reset, cfg_rdata is 0 and busy is 0. Every table entry reads 5'b11111.
- R2: The mask register holds all 32 bits as written. A write shows on cfg_rdata from the cycle after cfg_we, including bits that have no effect.
- R3: Suppose evt_pulse bit k is pulsed while mask bit k is set, with k in {0,2,3,4,5,6,7,28,29}. Then busy is high from the next cycle for exactly NUM_CHUNKS cycles.
- R4: When a sweep completes, every entry reads 5'b11111.
- R5: A pulse does not start a sweep and leaves every entry unchanged in either of two cases: its mask bit is clear, or its bit is outside the enabled set. Region-hit bits 16 to 19 belong to the second case.
- R6: While the block is idle, a write with wr_en=1 and wr_fail=0 stores wr_code at wr_idx.
- R7: A write with wr_en=1 and wr_fail=1 stores 5'b11111 at wr_idx, whatever wr_code holds.
- R8: Reads are registered. rd_code shows entry rd_idx one cycle after rd_idx is presented. rd_raw is 1 exactly when that code is 5'b11111.
- R9: An enabled event during a sweep restarts the sweep at entry 0. busy then stays high for NUM_CHUNKS cycles after the latest event.
- R10: During a sweep whose position is p, the position being the count of entries already cleared, a write to an index below p is stored. A write to an index of p or above is dropped, and so is a write in a cycle that carries an enabled event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Event mask write strobe |
| cfg_wdata | input | 32 | Event mask write data |
| cfg_rdata | output | 32 | Event mask readback |
| evt_pulse | input | 32 | Single-cycle event pulses, one bit per event position |
| busy | output | 1 | Invalidation sweep in progress |
| wr_en | input | 1 | Compressor status write strobe |
| wr_fail | input | 1 | Chunk store failed; write the reserved code |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_code | input | 5 | Status code to store |
| rd_idx | input | IDX_W | Entry index for the read |
| rd_code | output | 5 | Registered status code of the entry read |
| rd_raw | output | 1 | Registered flag: code is the reserved value |

## Verification
The bench pulses each of the 32 event bits under three kinds of mask:
- a cleared mask,
- a mask that holds only the inert bits,
- a mask that holds only that bit's own enable.

A design that decodes a wrong bit position either starts a spurious sweep, which wipes the prefilled codes, or misses a real one.

The bench also counts the busy cycles of a single sweep and of a restarted sweep. A design with an off-by-one end, or one that resumes a sweep instead of restarting it, shows the wrong count.

Mid-sweep writes are aimed at one index behind the sweep and one ahead of it. The entry ahead is then read back before the sweep reaches it. A design that lets an early write through shows the new code there instead of the prefilled one.

// File: rtl/cmi_pkg.sv
package cmi_pkg;

    localparam int MASK_W = 32;
    localparam int CODE_W = 5;

    typedef logic [CODE_W-1:0] code_t;

    // Reserved code: chunk is not compressed, fetch from the raw buffer.
    localparam code_t CODE_RAW = '1;

    // Event bit positions (a neighbour decodes these, so they are fixed).
    localparam int EV_DISP_REG    = 0;
    localparam int EV_CMP_EN      = 2;
    localparam int EV_SRC_SEL     = 3;
    localparam int EV_MIN_CMP     = 4;
    localparam int EV_ALPHA_EN    = 5;
    localparam int EV_ZSKIP_EN    = 6;
    localparam int EV_FCOPY       = 7;
    localparam int EV_EXT_WRITE   = 28;
    localparam int EV_STATIC_LOST = 29;

    localparam logic [MASK_W-1:0] LIVE_EVENTS =
        (MASK_W'(1) << EV_DISP_REG)  | (MASK_W'(1) << EV_CMP_EN)   |
        (MASK_W'(1) << EV_SRC_SEL)   | (MASK_W'(1) << EV_MIN_CMP)  |
        (MASK_W'(1) << EV_ALPHA_EN)  | (MASK_W'(1) << EV_ZSKIP_EN) |
        (MASK_W'(1) << EV_FCOPY)     | (MASK_W'(1) << EV_EXT_WRITE) |
        (MASK_W'(1) << EV_STATIC_LOST);

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_st_e;

    typedef struct packed {
        logic  en;
        logic  fail;
        code_t code;
    } cwr_t;

    function automatic code_t wr_value(cwr_t w);
        return w.fail ? CODE_RAW : w.code;
    endfunction

    function automatic logic is_raw(code_t c);
        return c == CODE_RAW;
    endfunction

endpackage

// File: rtl/cmi_event_mask.sv
module cmi_event_mask
    import cmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MASK_W-1:0] cfg_wdata,
    input  logic [MASK_W-1:0] evt_pulse,
    output logic [MASK_W-1:0] mask_q,
    output logic              trig
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (cfg_we) begin
            mask_q <= cfg_wdata;
        end
    end

    // Only the enabled event positions can raise a flush.
    assign trig = |(evt_pulse & mask_q & LIVE_EVENTS);

    assert_mask_rb_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> mask_q == $past(cfg_wdata));

endmodule

// File: rtl/cmi_sweep.sv
module cmi_sweep
    import cmi_pkg::*;
#(
    parameter int NUM_CHUNKS = 16,
    localparam int IDX_W = $clog2(NUM_CHUNKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHUNKS - 1);

    sweep_st_e        st_q;
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SW_IDLE;
            ptr_q <= '0;
        end else if (trig) begin
            st_q  <= SW_RUN;
            ptr_q <= '0;
        end else if (st_q == SW_RUN) begin
            if (ptr_q == LAST_IDX) begin
                st_q  <= SW_IDLE;
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign busy   = (st_q == SW_RUN);
    assign clr_en = busy && !trig;
    assign ptr    = ptr_q;

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> busy && ptr == '0);

    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !busy && !trig |=> !busy);

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        busy && !trig && ptr != LAST_IDX |=> busy && ptr == $past(ptr) + 1'b1);

    assert_end_R3: assert property (@(posedge clk) disable iff (rst)
        busy && !trig && ptr == LAST_IDX |=> !busy);

endmodule

// File: rtl/cmi_status_table.sv
module cmi_status_table
    import cmi_pkg::*;
#(
    parameter int NUM_CHUNKS = 16,
    localparam int IDX_W = $clog2(NUM_CHUNKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             busy,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] sweep_ptr,
    input  cwr_t             wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output code_t            rd_code,
    output logic             rd_raw
);

    code_t tbl_q [NUM_CHUNKS];
    logic  wr_ok;
    code_t rd_sel;

    // A write loses to a new event, and to any entry the sweep has yet to clear.
    assign wr_ok = wr.en && !trig && !(busy && (wr_idx >= sweep_ptr));

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CHUNKS; i++) begin
            if (rst) begin
                tbl_q[i] <= CODE_RAW;
            end else if (clr_en && sweep_ptr == IDX_W'(i)) begin
                tbl_q[i] <= CODE_RAW;
            end else if (wr_ok && wr_idx == IDX_W'(i)) begin
                tbl_q[i] <= wr_value(wr);
            end
        end
    end

    always_comb begin
        rd_sel = CODE_RAW;
        if (int'(rd_idx) < NUM_CHUNKS) begin
            rd_sel = tbl_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_code <= CODE_RAW;
            rd_raw  <= 1'b1;
        end else begin
            rd_code <= rd_sel;
            rd_raw  <= is_raw(rd_sel);
        end
    end

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> tbl_q[$past(sweep_ptr)] == CODE_RAW);

    assert_drop_R10: assert property (@(posedge clk) disable iff (rst)
        busy && !trig && wr.en && (wr_idx > sweep_ptr)
        |=> tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]));

    assert_fail_code_R7: assert property (@(posedge clk) disable iff (rst)
        !busy && !trig && wr.en && wr.fail |=> tbl_q[$past(wr_idx)] == CODE_RAW);

endmodule

// File: rtl/cmi_ctrl.sv
module cmi_ctrl
    import cmi_pkg::*;
#(
    parameter int NUM_CHUNKS = 16,
    localparam int IDX_W = $clog2(NUM_CHUNKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MASK_W-1:0] cfg_wdata,
    output logic [MASK_W-1:0] cfg_rdata,
    input  logic [MASK_W-1:0] evt_pulse,
    output logic              busy,
    input  logic              wr_en,
    input  logic              wr_fail,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CODE_W-1:0] rd_code,
    output logic              rd_raw
);

    logic             trig;
    logic             clr_en;
    logic [IDX_W-1:0] sweep_ptr;
    cwr_t             wr_req;

    assign wr_req = '{en: wr_en, fail: wr_fail, code: wr_code};

    cmi_event_mask u_mask (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .evt_pulse (evt_pulse),
        .mask_q    (cfg_rdata),
        .trig      (trig)
    );

    cmi_sweep #(.NUM_CHUNKS(NUM_CHUNKS)) u_sweep (
        .clk    (clk),
        .rst    (rst),
        .trig   (trig),
        .busy   (busy),
        .clr_en (clr_en),
        .ptr    (sweep_ptr)
    );

    cmi_status_table #(.NUM_CHUNKS(NUM_CHUNKS)) u_table (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .busy      (busy),
        .clr_en    (clr_en),
        .sweep_ptr (sweep_ptr),
        .wr        (wr_req),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .rd_code   (rd_code),
        .rd_raw    (rd_raw)
    );

endmodule

// File: tb/cmi_ctrl_tb.sv
module cmi_ctrl_tb;

    localparam int N     = 8;
    localparam int IW    = $clog2(N);
    localparam int RAWC  = 31;
    localparam logic [31:0] LIVE = 32'h3000_00FD;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] evt_pulse;
    logic        busy;
    logic        wr_en;
    logic        wr_fail;
    logic [IW-1:0] wr_idx;
    logic [4:0]  wr_code;
    logic [IW-1:0] rd_idx;
    logic [4:0]  rd_code;
    logic        rd_raw;

    int total = 0;
    int fails = 0;
    int expv [N];
    bit done = 0;

    always #2 clk = ~clk;

    cmi_ctrl #(.NUM_CHUNKS(N)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .evt_pulse(evt_pulse), .busy(busy),
        .wr_en(wr_en), .wr_fail(wr_fail), .wr_idx(wr_idx), .wr_code(wr_code),
        .rd_idx(rd_idx), .rd_code(rd_code), .rd_raw(rd_raw)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_entry(input int i, output int code);
        rd_idx = IW'(i);
        tick();
        code = int'(rd_code);
        check(rd_raw == (code == RAWC), "R8", "rd_raw flag", rd_raw, code == RAWC);
    endtask

    task automatic wr_entry(input int i, input int c, input bit fl);
        wr_en = 1'b1; wr_fail = fl; wr_idx = IW'(i); wr_code = 5'(c);
        tick();
        wr_en = 1'b0; wr_fail = 1'b0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        cfg_we = 1'b1; cfg_wdata = m;
        tick();
        cfg_we = 1'b0;
        check(cfg_rdata == m, "R2", "mask readback", cfg_rdata, m);
    endtask

    task automatic fill(input int base);
        for (int i = 0; i < N; i++) begin
            expv[i] = (base + i) % 30;
            wr_entry(i, expv[i], 1'b0);
        end
    endtask

    task automatic check_table(input string req);
        int c;
        for (int i = 0; i < N; i++) begin
            rd_entry(i, c);
            check(c == expv[i], req, $sformatf("entry %0d", i), c, expv[i]);
        end
    endtask

    task automatic pulse(input int k);
        evt_pulse = 32'd1 << k;
        tick();
        evt_pulse = '0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int c, n;
        int live_bits [9] = '{0, 2, 3, 4, 5, 6, 7, 28, 29};
        rst = 1'b1; cfg_we = 0; cfg_wdata = '0; evt_pulse = '0;
        wr_en = 0; wr_fail = 0; wr_idx = '0; wr_code = '0; rd_idx = '0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;

        // R1 reset state
        check(cfg_rdata == 0, "R1", "mask after reset", cfg_rdata, 0);
        check(busy == 0, "R1", "busy after reset", busy, 0);
        for (int i = 0; i < N; i++) expv[i] = RAWC;
        check_table("R1");

        // R2 mask holds all bits
        set_mask(32'hA5A5_5A5A);
        set_mask(32'hFFFF_FFFF);
        set_mask(32'h0);

        // R6 idle writes, R8 registered reads
        fill(1);
        check_table("R6");

        // R7 failed store writes the reserved code
        wr_entry(3, 5, 1'b1);
        expv[3] = RAWC;
        check_table("R7");

        // R5 cleared mask: no bit flushes
        fill(4);
        for (int k = 0; k < 32; k++) begin
            pulse(k);
            check(busy == 0, "R5", $sformatf("mask clear bit %0d", k), busy, 0);
        end
        check_table("R5");

        // R5 inert bits (incl. region hit 16..19) enabled in mask: no flush
        set_mask(~LIVE);
        for (int k = 0; k < 32; k++) begin
            pulse(k);
            check(busy == 0, "R5", $sformatf("inert bit %0d", k), busy, 0);
        end
        check_table("R5");

        // R3/R4 each live event bit alone
        foreach (live_bits[j]) begin
            set_mask(32'd1 << live_bits[j]);
            fill(live_bits[j]);
            pulse(live_bits[j]);
            count_busy(n);
            check(n == N, "R3", $sformatf("busy length bit %0d", live_bits[j]), n, N);
            for (int i = 0; i < N; i++) expv[i] = RAWC;
            check_table("R4");
        end

        // R9 restart mid-sweep
        set_mask(32'h1);
        fill(7);
        pulse(0);
        tick(); tick();
        pulse(0);
        count_busy(n);
        check(n == N, "R9", "busy length after restart", n, N);
        for (int i = 0; i < N; i++) expv[i] = RAWC;
        check_table("R9");

        // R10 mid-sweep writes: behind accepted, ahead dropped
        fill(11);
        begin
            int ahead_code;
            ahead_code = expv[6];
            pulse(0);                 // position 0
            tick(); tick(); tick();   // position 3
            wr_entry(2, 9, 1'b0);     // index 2 < 3: stored; now position 4
            wr_entry(6, 10, 1'b0);    // index 6 >= 4: dropped; now position 5
            rd_entry(6, c);           // entry 6 not yet cleared
            check(c == ahead_code, "R10", "write ahead of sweep dropped", c, ahead_code);
        end
        count_busy(n);
        for (int i = 0; i < N; i++) expv[i] = RAWC;
        expv[2] = 9;
        check_table("R10");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule